// File: doc/BRIEF.md
# Periodic Signal Coherent Averager

This block suppresses noise on a repeating signal whose period is known ahead of time. Each incoming sample belongs to a phase position inside the period. The block adds the sample into a per-phase accumulator held in an inferred RAM. Over several repetitions the noise, if its mean is near zero, partly cancels while the repeating waveform adds up coherently. The output for each accepted sample is the accumulator for that phase, divided by the averaging depth and rounded.

A phase counter advances by one on every accepted sample and wraps after the last phase. An optional marker input forces the current sample to phase zero, so an upstream source can realign the buffer. The averaging depth is a power of two, so the divide is a rounding arithmetic shift. Each accumulator carries enough guard bits that it can never overflow.

Once the configured number of periods has been summed, the block freezes. From then on it replays the stored averages phase by phase and ignores new sample values until the next reset. A period number output shows which repetition is being summed. A done flag shows the frozen state.

Top module: `periodic_averager`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid` is 0, `out_sample` is 0, `period_count` is 1 and `done` is 0.
- R2: Each sample with `in_valid` high is assigned a phase index. The index advances by one per accepted sample, and phase PERIOD-1 is followed by phase 0.
- R3: An accepted sample with `period_start` high is placed at phase 0, whatever the running phase. The next sample then takes phase 1. `period_start` has no effect while `in_valid` is low.
- R4: While not frozen, an accepted sample is added to its phase's accumulator. `out_sample` becomes floor((accumulator + 2^(AVG_LOG2-1)) / 2^AVG_LOG2), the new sum divided by the depth with halves rounded upward.
- R5: `period_count` starts at 1. It rises by one whenever an accepted sample lands on phase 0, provided it is not the first sample since reset and the block is not frozen.
- R6: When a sample lands on phase 0 while `period_count` equals 2^AVG_LOG2, `done` goes to 1 and stays there. From that sample on, accumulators do not change and `period_count` holds. `out_sample` gives the stored average of the sample's phase, regardless of the sample value.
- R7: Repeated full-scale positive or negative samples average back to exactly the full-scale value, without wrap-around.
- R8: Reset clears the buffer. The first sample at any phase after reset produces the rounded value of that sample alone divided by the depth.
- R9: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is low, `out_sample`, `period_count` and `done` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Signed two's-complement sample |
| period_start | input | 1 | Forces the strobed sample to phase 0 |
| out_valid | output | 1 | Output sample strobe, one cycle after `in_valid` |
| out_sample | output | SAMPLE_W | Signed averaged value for the sample's phase |
| period_count | output | $clog2(2^AVG_LOG2+1) | Number of the period being accumulated, from 1 |
| done | output | 1 | All periods accumulated; output frozen |

## Verification
The bench builds the block with an 8-bit sample, a period of 5 and an averaging depth of 4 (AVG_LOG2 = 2). These values let a few dozen samples cover every phase wrap and an early realignment marker. They also reach the full count of periods, the frozen replay, and a second reset. The narrow sample makes it cheap to drive the +127 and -128 extremes on every period. Those values test both the guard bits and the direction of rounding on exact halves.

// File: rtl/periodic_averager.sv
module periodic_averager #(
  parameter int SAMPLE_W = 16,
  parameter int PERIOD   = 300,
  parameter int AVG_LOG2 = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  input  logic signed [SAMPLE_W-1:0]          in_sample,
  input  logic                                period_start,
  output logic                                out_valid,
  output logic signed [SAMPLE_W-1:0]          out_sample,
  output logic [$clog2((1<<AVG_LOG2)+1)-1:0]  period_count,
  output logic                                done
);
  localparam int AVG_N = 1 << AVG_LOG2;
  localparam int ACC_W = SAMPLE_W + AVG_LOG2;
  localparam int PH_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int CNT_W = $clog2(AVG_N + 1);

  logic [PH_W-1:0]         phase, cur_ph, nxt_ph;
  logic                    started, done_q, new_per, freeze_now;
  logic [CNT_W-1:0]        count_q;
  logic signed [ACC_W-1:0] mem [PERIOD];
  logic [PERIOD-1:0]       written;
  logic signed [ACC_W-1:0] old_v, sum_v, pick_v, rnd_v;

  assign cur_ph     = period_start ? '0 : phase;
  assign nxt_ph     = (cur_ph == PH_W'(PERIOD - 1)) ? '0 : cur_ph + PH_W'(1);
  assign old_v      = written[cur_ph] ? mem[cur_ph] : '0;
  assign sum_v      = old_v + ACC_W'(in_sample);
  assign new_per    = in_valid && started && (cur_ph == '0);
  assign freeze_now = done_q || (new_per && count_q == CNT_W'(AVG_N));
  assign pick_v     = freeze_now ? old_v : sum_v;

  generate
    if (AVG_LOG2 == 0) begin : g_nodiv
      assign rnd_v = pick_v;
    end else begin : g_div
      assign rnd_v = (pick_v + (ACC_W'(1) <<< (AVG_LOG2 - 1))) >>> AVG_LOG2;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (in_valid && !freeze_now) mem[cur_ph] <= sum_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= '0;
      started    <= 1'b0;
      done_q     <= 1'b0;
      count_q    <= CNT_W'(1);
      written    <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        phase      <= nxt_ph;
        started    <= 1'b1;
        out_sample <= rnd_v[SAMPLE_W-1:0];
        if (!freeze_now) written[cur_ph] <= 1'b1;
        if (new_per && !freeze_now) count_q <= count_q + CNT_W'(1);
        if (freeze_now) done_q <= 1'b1;
      end
    end
  end

  assign period_count = count_q;
  assign done         = done_q;

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_sample) && $stable(period_count)));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (period_count != $past(period_count)) |-> (period_count == $past(period_count) + CNT_W'(1)));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(period_count)));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (period_count >= CNT_W'(1)) && (period_count <= CNT_W'(AVG_N)));

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_W'(PERIOD - 1));
endmodule

// File: tb/sim_periodic_averager.sv
module sim_periodic_averager;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int P  = 5;
  localparam int L  = 2;
  localparam int N  = 1 << L;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic period_start = 1'b0;
  logic out_valid;
  logic signed [W-1:0] out_sample;
  logic [CW-1:0] period_count;
  logic done;

  int checks = 0;
  int errors = 0;

  int m_acc [P];
  int m_ph, m_cnt;
  bit m_started, m_done;
  int last_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_averager #(.SAMPLE_W(W), .PERIOD(P), .AVG_LOG2(L)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .period_start(period_start), .out_valid(out_valid), .out_sample(out_sample),
    .period_count(period_count), .done(done));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; period_start = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < P; i++) m_acc[i] = 0;
    m_ph = 0; m_cnt = 1; m_started = 0; m_done = 0; last_out = 0;
  endtask

  task automatic push(input string req, input int s, input bit mk);
    int ph, old, val;
    bit newp, frz;
    ph   = mk ? 0 : m_ph;
    newp = m_started && (ph == 0);
    frz  = m_done || (newp && m_cnt == N);
    old  = m_acc[ph];
    val  = frz ? old : old + s;
    if (!frz) m_acc[ph] = old + s;
    if (newp && !frz) m_cnt++;
    if (frz) m_done = 1;
    m_ph = (ph == P - 1) ? 0 : ph + 1;
    m_started = 1;
    last_out = (val + (1 << (L - 1))) >>> L;
    @(negedge clk);
    in_valid = 1'b1; in_sample = W'(s); period_start = mk;
    @(posedge clk); #1;
    in_valid = 1'b0; period_start = 1'b0;
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, "out_sample", int'(out_sample), last_out);
    chk(req, "period_count", int'(period_count), m_cnt);
    chk(req, "done", int'(done), int'(m_done));
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "period_count in reset", int'(period_count), 1);
    do_reset();
    @(posedge clk); #1;
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "out_sample", int'(out_sample), 0);
    chk("R1", "period_count", int'(period_count), 1);
    chk("R1", "done", int'(done), 0);
  endtask

  task automatic t_first_period();
    push("R4", 10, 1'b0);
    chk("R4", "round 10/4", int'(out_sample), 3);
    push("R4", -6, 1'b0);
    chk("R4", "round -6/4", int'(out_sample), -1);
    push("R8", 6, 1'b0);
    chk("R8", "fresh entry 6/4", int'(out_sample), 2);
    push("R4", -2, 1'b0);
    chk("R4", "round -2/4", int'(out_sample), 0);
    push("R2", 127, 1'b0);
    chk("R2", "last phase", int'(out_sample), 32);
  endtask

  task automatic t_idle_and_wrap();
    int held;
    held = int'(out_sample);
    @(negedge clk); period_start = 1'b1; in_sample = 8'sd99;
    repeat (3) begin
      @(posedge clk); #1;
      chk("R9", "out_valid idle", int'(out_valid), 0);
      chk("R9", "out_sample held", int'(out_sample), held);
      chk("R3", "marker ignored idle, count", int'(period_count), 1);
    end
    period_start = 1'b0;
    push("R2", 2, 1'b0);
    chk("R5", "count after wrap", int'(period_count), 2);
    chk("R2", "wrap to phase 0 (10+2)/4", int'(out_sample), 3);
    push("R2", 2, 1'b0);
  endtask

  task automatic t_marker();
    push("R3", 4, 1'b1);
    chk("R5", "count after marker", int'(period_count), 3);
    chk("R3", "marker to phase 0 (12+4)/4", int'(out_sample), 4);
    push("R3", 1, 1'b0);
    chk("R3", "phase 1 after marker (-4+1)/4", int'(out_sample), -1);
    for (int i = 0; i < 3; i++) push("R2", 5, 1'b0);
  endtask

  task automatic t_freeze();
    for (int i = 0; i < P; i++) push("R4", i * 3 - 4, 1'b0);
    chk("R5", "count at depth", int'(period_count), N);
    chk("R6", "done before last period", int'(done), 0);
    push("R6", -100, 1'b0);
    chk("R6", "done set", int'(done), 1);
    for (int k = 0; k < 2 * P; k++) push("R6", (k % 2) ? 120 : -120, 1'b0);
    chk("R6", "count held", int'(period_count), N);
    push("R6", 50, 1'b1);
    chk("R6", "done stays", int'(done), 1);
  endtask

  task automatic t_reset_clears();
    do_reset();
    push("R8", 9, 1'b0);
    chk("R8", "phase 0 cleared", int'(out_sample), 2);
    push("R8", -9, 1'b0);
    chk("R8", "phase 1 cleared", int'(out_sample), -2);
    push("R8", 0, 1'b0);
    chk("R8", "phase 2 cleared", int'(out_sample), 0);
  endtask

  task automatic t_extremes();
    do_reset();
    for (int p = 0; p < N; p++) begin
      push("R7", 127, 1'b0);
      push("R7", -128, 1'b0);
      push("R7", 127, 1'b0);
      push("R7", -128, 1'b0);
      push("R7", 0, 1'b0);
    end
    push("R7", 0, 1'b0);
    chk("R7", "frozen +full", int'(out_sample), 127);
    push("R7", 0, 1'b0);
    chk("R7", "frozen -full", int'(out_sample), -128);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_period();
    t_idle_and_wrap();
    t_marker();
    t_freeze();
    t_reset_clears();
    t_extremes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule